// File: doc/BRIEF.md
# Per-Residency Core Block Detector

This block watches the lookup stream of a direct-mapped cache and counts how many times each line is referenced during one residency. A residency begins when a block is filled into a line and ends when a different block displaces it. Once a line's count reaches a threshold supplied with each access, the line is classed as a member of the core working set. Lines that stay below the threshold are classed as transient. A replacement policy, a bypass filter or a profiling unit can act on that class.

Only tags, valid bits and counters are held. Data storage, the refill path and backing memory lie outside the block. Each access is answered one cycle later with the hit/miss outcome, the line's count after that access and the core flag. When the access displaces a resident block, an eviction report carries that block's tag and final count in the same cycle. With the default parameters the cache is 16 KB: 256 lines of 64 bytes.

Top module: `core_ws_detector`

## Requirements
- R1: After reset every line is invalid, so the first access to any line misses, reports count 1 and produces no eviction report.
- R2: Address bits [5:0] are the byte offset within a 64-byte block and have no effect on lookup. Addresses that differ only in those bits hit the same resident block.
- R3: Address bits [13:6] select one of 256 lines and bits [31:14] form the tag. Two addresses with the same index and different tags displace each other. Accesses to other lines leave a line's tag and count unchanged.
- R4: A miss fills the line with count 1. Each hit to the resident block raises its count by one.
- R5: A count that has reached 1023 stays at 1023 on further hits and never wraps.
- R6: resp_core is 1 exactly when the count after the current access is greater than or equal to the threshold sampled with that access. A threshold of 0 classes every access as core.
- R7: A miss on a valid line raises evict_valid for exactly one cycle, alongside the miss response, with the displaced tag and its final count.
- R8: After an eviction, a later refill of the displaced address starts a new residency at count 1.
- R9: All responses appear on the cycle after the accepted access. resp_valid and evict_valid are 0 in any cycle that follows a cycle without req_valid.
- R10: Cycles without req_valid change no line's count or tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Lookup present this cycle |
| req_addr | input | 32 | Byte address of the lookup |
| threshold | input | 10 | Core threshold applied to this lookup |
| resp_valid | output | 1 | Response for the previous cycle's lookup |
| resp_hit | output | 1 | Lookup found its block resident |
| resp_count | output | 10 | Residency count after the lookup |
| resp_core | output | 1 | Count has reached the threshold |
| evict_valid | output | 1 | A resident block was displaced |
| evict_tag | output | 18 | Tag of the displaced block |
| evict_count | output | 10 | Final count of the displaced residency |

## Verification
Four kinds of stream are used. Repeated hits with varied byte offsets show that the counter advances and the offset is ignored. An interleaving of two tags on one index, mixed with traffic to a neighbouring line, tells conflicts apart from independent lines and checks that a new residency begins at 1. A run of 1100 hits on one line with the threshold at 1000 exposes the off-by-one at the threshold and the saturation at 1023, and displacing that line then shows that a saturated final count is reported. Idle gaps and a mid-run reset confirm that state neither drifts nor survives reset.

// File: rtl/cws_pkg.sv
package cws_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE    = 2'd0,
    ACC_HIT     = 2'd1,
    ACC_FILL    = 2'd2,
    ACC_REPLACE = 2'd3
  } access_kind_e;
endpackage

// File: rtl/cws_addr_split.sv
module cws_addr_split #(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 6,
  parameter int INDEX_W  = 8,
  localparam int TAG_W   = ADDR_W - OFFSET_W - INDEX_W
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [INDEX_W-1:0] index,
  output logic [TAG_W-1:0]   tag
);
  // The byte offset is dropped: a block is the unit of residency.
  assign index = addr[OFFSET_W +: INDEX_W];
  assign tag   = addr[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/cws_count_update.sv
module cws_count_update #(
  parameter int CNT_W = 10
) (
  input  logic             hit,
  input  logic [CNT_W-1:0] old_count,
  input  logic [CNT_W-1:0] threshold,
  output logic [CNT_W-1:0] new_count,
  output logic             is_core
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_comb begin
    if (!hit) begin
      new_count = CNT_ONE;               // the filling reference counts
    end else if (old_count == CNT_MAX) begin
      new_count = CNT_MAX;               // saturate, never wrap
    end else begin
      new_count = old_count + CNT_ONE;
    end
    is_core = (new_count >= threshold);
  end
endmodule

// File: rtl/cws_line_store.sv
module cws_line_store #(
  parameter int INDEX_W = 8,
  parameter int TAG_W   = 18,
  parameter int CNT_W   = 10,
  localparam int LINES  = 1 << INDEX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INDEX_W-1:0] rd_index,
  output logic               rd_valid,
  output logic [TAG_W-1:0]   rd_tag,
  output logic [CNT_W-1:0]   rd_count,
  input  logic               wr_en,
  input  logic [INDEX_W-1:0] wr_index,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [CNT_W-1:0]   wr_count
);
  logic [LINES-1:0]       valid_vec;
  logic [LINES*TAG_W-1:0] tag_flat;
  logic [LINES*CNT_W-1:0] cnt_flat;

  for (genvar gi = 0; gi < LINES; gi++) begin : g_line
    logic             line_we;
    logic             v_q;
    logic [TAG_W-1:0] t_q;
    logic [CNT_W-1:0] c_q;

    assign line_we = wr_en && (wr_index == INDEX_W'(gi));

    // Valid bit and counter are cleared by reset.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        c_q <= '0;
      end else if (line_we) begin
        v_q <= 1'b1;
        c_q <= wr_count;
      end
    end

    // Tags are only meaningful under a set valid bit: no reset.
    always_ff @(posedge clk) begin
      if (line_we) begin
        t_q <= wr_tag;
      end
    end

    assign valid_vec[gi]                = v_q;
    assign tag_flat[gi*TAG_W +: TAG_W]  = t_q;
    assign cnt_flat[gi*CNT_W +: CNT_W]  = c_q;
  end

  assign rd_valid = valid_vec[rd_index];
  assign rd_tag   = tag_flat[rd_index*TAG_W +: TAG_W];
  assign rd_count = cnt_flat[rd_index*CNT_W +: CNT_W];
endmodule

// File: rtl/core_ws_detector.sv
module core_ws_detector #(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 6,
  parameter int INDEX_W  = 8,
  parameter int CNT_W    = 10,
  localparam int TAG_W   = ADDR_W - OFFSET_W - INDEX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  threshold,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [CNT_W-1:0]  resp_count,
  output logic              resp_core,
  output logic              evict_valid,
  output logic [TAG_W-1:0]  evict_tag,
  output logic [CNT_W-1:0]  evict_count
);
  import cws_pkg::*;

  logic [INDEX_W-1:0] acc_index;
  logic [TAG_W-1:0]   acc_tag;
  logic               rd_valid;
  logic [TAG_W-1:0]   rd_tag;
  logic [CNT_W-1:0]   rd_count;
  logic               hit;
  logic [CNT_W-1:0]   new_count;
  logic               is_core;
  access_kind_e       kind;

  cws_addr_split #(
    .ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .INDEX_W(INDEX_W)
  ) u_split (
    .addr(req_addr), .index(acc_index), .tag(acc_tag)
  );

  cws_line_store #(
    .INDEX_W(INDEX_W), .TAG_W(TAG_W), .CNT_W(CNT_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_index(acc_index), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_count(rd_count),
    .wr_en(req_valid), .wr_index(acc_index), .wr_tag(acc_tag), .wr_count(new_count)
  );

  cws_count_update #(
    .CNT_W(CNT_W)
  ) u_count (
    .hit(hit), .old_count(rd_count), .threshold(threshold),
    .new_count(new_count), .is_core(is_core)
  );

  // Classification of the current access.
  assign hit = rd_valid && (rd_tag == acc_tag);

  always_comb begin
    if (!req_valid)     kind = ACC_IDLE;
    else if (hit)       kind = ACC_HIT;
    else if (rd_valid)  kind = ACC_REPLACE;
    else                kind = ACC_FILL;
  end

  // Next-state for the response registers.
  logic              resp_valid_d, resp_hit_d, resp_core_d, evict_valid_d;
  logic [CNT_W-1:0]  resp_count_d, evict_count_d;
  logic [TAG_W-1:0]  evict_tag_d;
  logic              resp_load, evict_load;

  always_comb begin
    resp_load     = (kind != ACC_IDLE);
    evict_load    = (kind == ACC_REPLACE);
    resp_valid_d  = resp_load;
    evict_valid_d = evict_load;
    resp_hit_d    = (kind == ACC_HIT);
    resp_count_d  = new_count;
    resp_core_d   = is_core;
    evict_tag_d   = rd_tag;
    evict_count_d = rd_count;
  end

  // Strobes load every cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      evict_valid <= 1'b0;
    end else begin
      resp_valid  <= resp_valid_d;
      evict_valid <= evict_valid_d;
    end
  end

  // Payload registers load only under their enables.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_hit   <= 1'b0;
      resp_count <= '0;
      resp_core  <= 1'b0;
    end else if (resp_load) begin
      resp_hit   <= resp_hit_d;
      resp_count <= resp_count_d;
      resp_core  <= resp_core_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evict_tag   <= '0;
      evict_count <= '0;
    end else if (evict_load) begin
      evict_tag   <= evict_tag_d;
      evict_count <= evict_count_d;
    end
  end

  // A fill always reports exactly one reference (R4).
  p_fresh_r4: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_hit |-> resp_count == CNT_W'(1));

  // A hit can never report a wrapped count (R5).
  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_hit |-> resp_count > CNT_W'(1));

  // Core flag matches the threshold given with the access (R6).
  p_core_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_core == (resp_count >= $past(threshold)));

  // Eviction only accompanies a miss response (R7).
  p_evict_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> resp_valid && !resp_hit);

  // A displaced residency had at least its filling reference (R7).
  p_evict_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> evict_count != '0);

  // No response without an access one cycle earlier (R9).
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid && !evict_valid);
endmodule

// File: tb/core_ws_detector_tb.sv
module core_ws_detector_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [9:0]  threshold;
  logic        resp_valid, resp_hit, resp_core, evict_valid;
  logic [9:0]  resp_count, evict_count;
  logic [17:0] evict_tag;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  core_ws_detector u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .threshold(threshold), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_count(resp_count), .resp_core(resp_core), .evict_valid(evict_valid),
    .evict_tag(evict_tag), .evict_count(evict_count)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [9:0]  thr;
    logic        hit;
    logic [9:0]  cnt;
    logic        core;
    logic        ev;
    logic [17:0] etag;
    logic [9:0]  ecnt;
  } vec_t;

  // A = 0x40 (line 1, tag 0), B = 0x4040 (line 1, tag 1), C = 0x80 (line 2)
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0040, 10'd3,  1'b0, 10'd1, 1'b0, 1'b0, 18'd0, 10'd0}, // R1 R4 fill
    '{32'h0000_007F, 10'd3,  1'b1, 10'd2, 1'b0, 1'b0, 18'd0, 10'd0}, // R2 offset ignored
    '{32'h0000_0045, 10'd3,  1'b1, 10'd3, 1'b1, 1'b0, 18'd0, 10'd0}, // R6 reaches thr
    '{32'h0000_0080, 10'd3,  1'b0, 10'd1, 1'b0, 1'b0, 18'd0, 10'd0}, // R3 other line
    '{32'h0000_0040, 10'd10, 1'b1, 10'd4, 1'b0, 1'b0, 18'd0, 10'd0}, // R3 R6 per-access thr
    '{32'h0000_4040, 10'd3,  1'b0, 10'd1, 1'b0, 1'b1, 18'd0, 10'd4}, // R7 evict A
    '{32'h0000_0040, 10'd3,  1'b0, 10'd1, 1'b0, 1'b1, 18'd1, 10'd1}, // R8 new residency
    '{32'h0000_0040, 10'd3,  1'b1, 10'd2, 1'b0, 1'b0, 18'd0, 10'd0}, // R4 hit
    '{32'h0000_0080, 10'd0,  1'b1, 10'd2, 1'b1, 1'b0, 18'd0, 10'd0}, // R6 thr 0
    '{32'h0000_0040, 10'd2,  1'b1, 10'd3, 1'b1, 1'b0, 18'd0, 10'd0}  // R6 above thr
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One access; outputs sampled at the negedge after the capturing posedge.
  task automatic access(input logic [31:0] a, input logic [9:0] t);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    threshold = t;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [63:0] pack_out();
    return 64'({resp_valid, resp_hit, resp_count, resp_core,
                evict_valid, evict_tag, evict_count});
  endfunction

  function automatic logic [63:0] pack_exp(input vec_t v);
    return 64'({1'b1, v.hit, v.cnt, v.core, v.ev,
                v.ev ? v.etag : 18'd0, v.ev ? v.ecnt : 10'd0});
  endfunction

  function automatic logic [63:0] masked_out();
    return 64'({resp_valid, resp_hit, resp_count, resp_core, evict_valid,
                evict_valid ? evict_tag : 18'd0, evict_valid ? evict_count : 10'd0});
  endfunction

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    threshold = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset outputs", 64'({resp_valid, evict_valid}), 64'd0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      access(VECS[i].addr, VECS[i].thr);
      check($sformatf("R4/R6/R7 vector %0d", i), masked_out(), pack_exp(VECS[i]));
    end

    // R7 R9: eviction pulse lasts one cycle, idle gives no response
    access(32'h0000_4040, 10'd3);
    check("R7 evict pulse", 64'({evict_valid, evict_tag, evict_count}),
          64'({1'b1, 18'd0, 10'd3}));
    @(negedge clk);
    check("R9 idle no response", 64'({resp_valid, evict_valid}), 64'd0);

    // R10: idle cycles leave line 2 (C, count 2) untouched
    repeat (20) @(negedge clk);
    access(32'h0000_0080, 10'd3);
    check("R10 idle preserves count", 64'({resp_hit, resp_count}), 64'({1'b1, 10'd3}));

    // R5 R6: 1100 accesses to D = 0x100 (line 4) with threshold 1000
    for (int k = 1; k <= 1100; k++) begin
      access(32'h0000_0100 + 32'(k % 64), 10'd1000);
      if (k == 999)
        check("R6 below 1000", 64'({resp_count, resp_core}), 64'({10'd999, 1'b0}));
      if (k == 1000)
        check("R6 at 1000", 64'({resp_count, resp_core}), 64'({10'd1000, 1'b1}));
      if (k == 1023)
        check("R5 reach max", 64'(resp_count), 64'd1023);
    end
    check("R5 saturated", 64'({resp_hit, resp_count, resp_core}),
          64'({1'b1, 10'd1023, 1'b1}));

    // R7: displace saturated D with E = 0x10100 (tag 4)
    access(32'h0001_0100, 10'd5);
    check("R7 saturated evict", pack_out(),
          64'({1'b1, 1'b0, 10'd1, 1'b0, 1'b1, 18'd0, 10'd1023}));

    // R1: reset mid-run clears all lines
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    access(32'h0000_0080, 10'd3);
    check("R1 after reset miss", pack_out(),
          64'({1'b1, 1'b0, 10'd1, 1'b0, 1'b0, 18'd0, 10'd0}));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule